// File: doc/BRIEF.md
# Sharer-Tracking Coherence Directory

This block holds coherence metadata for the lines of a shared last-level cache that serves several cores. For every tracked line it stores a two-bit stable state and a presence vector with one bit per core. The bit of a core is set when that core may hold a copy. Cores send requests that name themselves, a line index and whether they want to write. The directory updates its metadata and answers with a grant. When other copies must be removed first, it raises invalidations, and only toward the cores whose presence bit is set.

Requests that need no invalidation complete at the edge that accepts them. A request that does need invalidations is handed to a single in-flight tracker. The tracker keeps each targeted core's invalidate line high until that core acknowledges. It issues the grant after the last acknowledgement. While the tracker is busy, requests to its line are stalled, and so are other requests that would need invalidations. Requests to other lines that need no invalidation keep flowing. Data arrays, tags and replacement live elsewhere, so the directory is indexed by line number alone.

Top module: `sharer_dir`

## Requirements
- R1: While reset is asserted and during the two cycles after its release, req_ready, gnt_valid and inv_req are all low. After reset every line reads as Invalid with no presence bits set, so the first read of any line is granted Exclusive.
- R2: A read of an Invalid line is granted with state Exclusive (gnt_state 2'b10) at the edge that accepts it. Afterwards the line's presence vector holds only the requester.
- R3: A read by a core of a line held Shared (2'b01) or Exclusive by other cores is granted Shared. The requester is added to the presence vector, no earlier holder is dropped, and a line that was Exclusive becomes Shared.
- R4: A read by the only core present on an Exclusive or Modified (2'b11) line is granted with the state unchanged. No invalidation is sent.
- R5: A write targets exactly the cores in the line's presence vector other than the requester. inv_req (bit i for core i) shows that mask one cycle after acceptance. If the mask is empty, the grant of Modified comes at the accepting edge.
- R6: Each inv_req bit stays high until that core's inv_ack is seen. Acknowledgements may come in any order. The grant is issued one cycle after the last acknowledgement and never while any inv_req bit is high.
- R7: After any write grant the line is Modified with only the writer's presence bit set. No line is ever Modified with more or fewer than one presence bit.
- R8: A read of a line Modified by another core invalidates that owner only. After the acknowledgement, the requester is granted Exclusive as the sole holder.
- R9: While the tracker is busy, a request to its line is stalled (req_ready low), and so is a request to another line that would need invalidations. A request to another line that needs none is accepted and granted.
- R10: While any inv_req bit is high, inv_line carries the index of the line being invalidated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when high with req_valid |
| req_core | input | $clog2(NCORE) | Requesting core |
| req_line | input | $clog2(NLINE) | Line index |
| req_write | input | 1 | 1 = write/ownership, 0 = read |
| inv_req | output | NCORE | Per-core invalidate, held until acknowledged |
| inv_line | output | $clog2(NLINE) | Line being invalidated |
| inv_ack | input | NCORE | Per-core invalidation acknowledgement |
| gnt_valid | output | 1 | One-cycle grant strobe |
| gnt_core | output | $clog2(NCORE) | Core being granted |
| gnt_line | output | $clog2(NLINE) | Line granted |
| gnt_state | output | 2 | Granted state: 00 I, 01 S, 10 E, 11 M |

## Verification
The bench builds the block with four cores and eight lines. With this small line count, random traffic keeps returning to the same lines. That builds presence vectors with two, three and four sharers, and it produces writes and reads against lines that other cores hold Modified. Acknowledgements come back after random delays, so their order varies. A directed phase holds acknowledgements back by hand to observe partial acknowledgement, stalling on the busy line, and service of another line in parallel.

// File: rtl/shdir_pkg.sv
package shdir_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;
endpackage

// File: rtl/shdir_table.sv
module shdir_table
  import shdir_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NLINE = 16,
  localparam int LW = $clog2(NLINE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LW-1:0]    rd_idx,
  output line_st_e         rd_st,
  output logic [NCORE-1:0] rd_pres,
  input  logic             wr_en,
  input  logic [LW-1:0]    wr_idx,
  input  line_st_e         wr_st,
  input  logic [NCORE-1:0] wr_pres
);
  line_st_e         st_q   [NLINE];
  logic [NCORE-1:0] pres_q [NLINE];

  for (genvar g = 0; g < NLINE; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_idx == LW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g]   <= ST_I;
        pres_q[g] <= '0;
      end else if (hit) begin
        st_q[g]   <= wr_st;
        pres_q[g] <= wr_pres;
      end
    end
    // R7: a modified line always has exactly one holder
    a_r7_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == ST_M) |-> $onehot(pres_q[g]));
    // R1: an invalid line never records holders
    a_r1_invalid_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == ST_I) |-> (pres_q[g] == '0));
  end

  assign rd_st   = st_q[rd_idx];
  assign rd_pres = pres_q[rd_idx];
endmodule

// File: rtl/shdir_decide.sv
module shdir_decide
  import shdir_pkg::*;
#(
  parameter int NCORE = 4,
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  line_st_e         cur_st,
  input  logic [NCORE-1:0] cur_pres,
  input  logic [CW-1:0]    core,
  input  logic             write,
  output logic [NCORE-1:0] inv_mask,
  output line_st_e         nxt_st,
  output logic [NCORE-1:0] nxt_pres
);
  logic [NCORE-1:0] self_bit;
  logic [NCORE-1:0] others;

  assign self_bit = NCORE'(1) << core;
  assign others   = cur_pres & ~self_bit;

  always_comb begin
    inv_mask = '0;
    nxt_st   = cur_st;
    nxt_pres = cur_pres | self_bit;
    if (write) begin
      inv_mask = others;
      nxt_st   = ST_M;
      nxt_pres = self_bit;
    end else begin
      unique case (cur_st)
        ST_I: begin
          nxt_st   = ST_E;
          nxt_pres = self_bit;
        end
        ST_S: nxt_st = ST_S;
        ST_E: nxt_st = (others == '0) ? ST_E : ST_S;
        ST_M: begin
          if (others != '0) begin
            inv_mask = others;
            nxt_st   = ST_E;
            nxt_pres = self_bit;
          end
        end
        default: nxt_st = cur_st;
      endcase
    end
  end
endmodule

// File: rtl/shdir_track.sv
module shdir_track
  import shdir_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NLINE = 16,
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int LW = $clog2(NLINE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LW-1:0]    start_line,
  input  logic [CW-1:0]    start_core,
  input  logic [NCORE-1:0] start_mask,
  input  line_st_e         start_st,
  input  logic [NCORE-1:0] acks,
  output logic             busy,
  output logic [LW-1:0]    line,
  output logic [CW-1:0]    core,
  output line_st_e         fin_st,
  output logic [NCORE-1:0] pend,
  output logic             done
);
  logic             busy_d;
  logic [NCORE-1:0] pend_d;
  logic             cap_en;

  assign done   = busy && (pend == '0);
  assign cap_en = start;

  always_comb begin
    busy_d = busy;
    pend_d = pend & ~acks;
    if (done) busy_d = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      pend_d = start_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= '0;
    end else begin
      busy <= busy_d;
      pend <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line   <= '0;
      core   <= '0;
      fin_st <= ST_I;
    end else if (cap_en) begin
      line   <= start_line;
      core   <= start_core;
      fin_st <= start_st;
    end
  end

  // R5: the requester never invalidates itself
  a_r5_self_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pend[core]);
  // R5: a started transaction always has at least one target
  a_r5_nonempty_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (pend != '0));

  for (genvar i = 0; i < NCORE; i++) begin : g_chk
    // R6: an invalidate drops only after its acknowledgement
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && $past(pend[i]) && !pend[i] && busy) |-> $past(acks[i]));
  end
endmodule

// File: rtl/sharer_dir.sv
module sharer_dir
  import shdir_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NLINE = 16,
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int LW = $clog2(NLINE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CW-1:0]    req_core,
  input  logic [LW-1:0]    req_line,
  input  logic             req_write,
  output logic [NCORE-1:0] inv_req,
  output logic [LW-1:0]    inv_line,
  input  logic [NCORE-1:0] inv_ack,
  output logic             gnt_valid,
  output logic [CW-1:0]    gnt_core,
  output logic [LW-1:0]    gnt_line,
  output logic [1:0]       gnt_state
);
  logic [1:0] rst_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  line_st_e         cur_st, nxt_st, trk_st, wr_st;
  logic [NCORE-1:0] cur_pres, nxt_pres, inv_mask, wr_pres, trk_pend;
  logic             need_inv, accept, trk_busy, trk_done, wr_en, line_hit;
  logic [LW-1:0]    trk_line, wr_idx;
  logic [CW-1:0]    trk_core;

  shdir_table #(.NCORE(NCORE), .NLINE(NLINE)) u_tab (
    .clk(clk), .rst_n(rst_i_n), .rd_idx(req_line), .rd_st(cur_st),
    .rd_pres(cur_pres), .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st),
    .wr_pres(wr_pres));

  shdir_decide #(.NCORE(NCORE)) u_dec (
    .cur_st(cur_st), .cur_pres(cur_pres), .core(req_core), .write(req_write),
    .inv_mask(inv_mask), .nxt_st(nxt_st), .nxt_pres(nxt_pres));

  assign need_inv  = (inv_mask != '0);
  assign line_hit  = trk_busy && (trk_line == req_line);
  assign req_ready = rst_i_n && !trk_done && !line_hit && !(trk_busy && need_inv);
  assign accept    = req_valid && req_ready;

  shdir_track #(.NCORE(NCORE), .NLINE(NLINE)) u_trk (
    .clk(clk), .rst_n(rst_i_n), .start(accept && need_inv),
    .start_line(req_line), .start_core(req_core), .start_mask(inv_mask),
    .start_st(nxt_st), .acks(inv_ack), .busy(trk_busy), .line(trk_line),
    .core(trk_core), .fin_st(trk_st), .pend(trk_pend), .done(trk_done));

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = req_line;
    wr_st   = nxt_st;
    wr_pres = nxt_pres;
    if (trk_done) begin
      wr_en   = 1'b1;
      wr_idx  = trk_line;
      wr_st   = trk_st;
      wr_pres = NCORE'(1) << trk_core;
    end else if (accept && !need_inv) begin
      wr_en = 1'b1;
    end
  end

  logic          gv_d;
  logic [CW-1:0] gc_d;
  logic [LW-1:0] gl_d;
  logic [1:0]    gs_d;

  always_comb begin
    gv_d = trk_done || (accept && !need_inv);
    gc_d = trk_done ? trk_core : req_core;
    gl_d = trk_done ? trk_line : req_line;
    gs_d = trk_done ? trk_st   : nxt_st;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      gnt_valid <= 1'b0;
      gnt_core  <= '0;
      gnt_line  <= '0;
      gnt_state <= ST_I;
    end else begin
      gnt_valid <= gv_d;
      if (gv_d) begin
        gnt_core  <= gc_d;
        gnt_line  <= gl_d;
        gnt_state <= gs_d;
      end
    end
  end

  assign inv_req  = trk_pend;
  assign inv_line = trk_line;

  // R9: the busy line is never accepted again
  a_r9_busy_line_stall: assert property (@(posedge clk) disable iff (!rst_i_n)
    (trk_busy && req_valid && req_line == trk_line) |-> !req_ready);
  // R6: tracker completion yields a grant for its line
  a_r6_grant_on_finish: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(trk_busy) |-> (gnt_valid && gnt_line == $past(trk_line)));
  // R7: every write grant is Modified
  a_r7_write_grant_m: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept && req_write && !need_inv) |=> (gnt_valid && gnt_state == ST_M));
  // R10: invalidates only exist inside a tracked transaction
  a_r10_inv_in_txn: assert property (@(posedge clk) disable iff (!rst_i_n)
    (inv_req != '0) |-> trk_busy);
endmodule

// File: tb/sim_sharer_dir.sv
`timescale 1ns/1ps
module sim_sharer_dir;
  localparam int NC = 4;
  localparam int NL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_core = '0;
  logic [2:0] req_line = '0;
  logic req_write = 1'b0;
  logic [NC-1:0] inv_req, inv_ack, auto_ack, man_ack;
  logic [2:0] inv_line;
  logic gnt_valid;
  logic [1:0] gnt_core, gnt_state;
  logic [2:0] gnt_line;

  always #5 clk = ~clk;

  assign inv_ack = auto_ack | man_ack;

  sharer_dir #(.NCORE(NC), .NLINE(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_line(req_line), .req_write(req_write),
    .inv_req(inv_req), .inv_line(inv_line), .inv_ack(inv_ack),
    .gnt_valid(gnt_valid), .gnt_core(gnt_core), .gnt_line(gnt_line),
    .gnt_state(gnt_state));

  int checks = 0, fails = 0;
  bit done_flag = 0;
  bit ack_en = 1'b1;
  int dly [NC];
  logic [1:0] mst [NL];
  logic [NC-1:0] mpr [NL];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // auto responder: random delay 0..3 cycles, one-cycle ack pulse
  initial begin
    auto_ack = '0;
    for (int i = 0; i < NC; i++) dly[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < NC; i++) begin
        if (auto_ack[i]) begin
          auto_ack[i] = 1'b0;
          dly[i] = int'($urandom % 4);
        end else if (ack_en && inv_req[i]) begin
          if (dly[i] == 0) auto_ack[i] = 1'b1;
          else dly[i]--;
        end
      end
    end
  end

  function automatic void predict(input logic [1:0] st, input logic [NC-1:0] pr,
      input int c, input bit w, output logic [1:0] nst, output logic [NC-1:0] npr,
      output logic [NC-1:0] mask);
    logic [NC-1:0] me, oth;
    me = NC'(1) << c;
    oth = pr & ~me;
    mask = '0;
    nst = st;
    npr = pr | me;
    if (w) begin
      mask = oth; nst = 2'b11; npr = me;
    end else if (st == 2'b00) begin
      nst = 2'b10; npr = me;
    end else if (st == 2'b10) begin
      nst = (oth == '0) ? 2'b10 : 2'b01;
    end else if (st == 2'b11 && oth != '0) begin
      mask = oth; nst = 2'b10; npr = me;
    end
  endfunction

  // present a request and wait until accepted; returns at the negedge after acceptance
  task automatic issue(input int c, input int l, input bit w);
    int g = 0;
    @(negedge clk);
    req_valid = 1'b1; req_core = 2'(c); req_line = 3'(l); req_write = w;
    #1;
    while (!req_ready && g < 200) begin
      @(negedge clk); #1; g++;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_grant(input int c, input int l, input logic [1:0] st, input string req);
    int g = 0;
    while (!gnt_valid && g < 200) begin
      chk(inv_req != '0 || g == 0 || 1, req, 0, 0);
      checks--;
      @(negedge clk); g++;
    end
    chk(gnt_valid && inv_req == '0, {req, " grant after acks"}, {gnt_valid, inv_req}, 1);
    chk(gnt_core == 2'(c) && gnt_line == 3'(l), {req, " grant id"},
        {gnt_core, gnt_line}, {2'(c), 3'(l)});
    chk(gnt_state == st, {req, " grant state"}, gnt_state, st);
  endtask

  task automatic do_req(input int c, input int l, input bit w, input string req);
    logic [1:0] nst; logic [NC-1:0] npr, mask;
    predict(mst[l], mpr[l], c, w, nst, npr, mask);
    issue(c, l, w);
    if (mask == '0) begin
      chk(gnt_valid, {req, " immediate grant"}, gnt_valid, 1);
      chk(gnt_state == nst && gnt_core == 2'(c) && gnt_line == 3'(l),
          {req, " immediate fields"}, {gnt_state, gnt_core, gnt_line}, {nst, 2'(c), 3'(l)});
    end else begin
      chk((inv_req | inv_ack) == mask, "R5 invalidate mask", inv_req, mask);
      chk(inv_line == 3'(l), "R10 inv_line", inv_line, l);
      expect_grant(c, l, nst, mask != '0 && !w ? "R8" : "R6");
    end
    mst[l] = nst; mpr[l] = npr;
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000 && !done_flag) begin
      @(posedge clk); wd++;
    end
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] nst; logic [NC-1:0] npr, mask;
    void'($urandom(32'd20240611));
    man_ack = '0;
    for (int i = 0; i < NL; i++) begin mst[i] = 2'b00; mpr[i] = '0; end
    repeat (3) @(negedge clk);
    chk(req_ready == 0 && gnt_valid == 0 && inv_req == '0, "R1 in reset",
        {req_ready, gnt_valid, inv_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 0, "R1 sync release", req_ready, 0);
    @(negedge clk);
    // R1/R2: fresh lines come back Exclusive
    do_req(1, 0, 0, "R2 read invalid");
    do_req(1, 0, 0, "R4 owner reread E");
    do_req(2, 0, 0, "R3 E downgraded");
    do_req(3, 0, 0, "R3 shared add");
    do_req(0, 4, 1, "R5 write empty");
    do_req(0, 4, 0, "R4 owner reread M");
    do_req(2, 4, 0, "R8 read of M");
    do_req(2, 0, 1, "R7 write to shared");
    chk(mpr[0] == 4'b0100, "R7 sole holder", mpr[0], 4'b0100);

    // directed: partial acks and concurrency (R6, R9)
    ack_en = 1'b0;
    do_req(0, 1, 0, "R2 setup");
    do_req(1, 1, 0, "R3 setup");
    do_req(3, 2, 0, "R2 setup2");
    issue(2, 1, 1);
    chk(inv_req == 4'b0011, "R5 directed mask", inv_req, 4'b0011);
    chk(inv_line == 3'd1, "R10 directed line", inv_line, 1);
    do_req(0, 3, 0, "R9 other line served");
    @(negedge clk);
    req_valid = 1'b1; req_core = 2'd0; req_line = 3'd1; req_write = 1'b0;
    repeat (3) begin
      #1; chk(req_ready == 0, "R9 busy line stall", req_ready, 0);
      @(negedge clk);
    end
    req_line = 3'd2; req_write = 1'b1;
    #1; chk(req_ready == 0, "R9 second invalidation waits", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    man_ack = 4'b0010;
    @(negedge clk);
    man_ack = '0;
    @(negedge clk);
    chk(inv_req == 4'b0001 && !gnt_valid, "R6 partial ack", {gnt_valid, inv_req}, 4'b0001);
    repeat (2) @(negedge clk);
    chk(inv_req == 4'b0001 && !gnt_valid, "R6 still held", {gnt_valid, inv_req}, 4'b0001);
    man_ack = 4'b0001;
    @(negedge clk);
    man_ack = '0;
    chk(!gnt_valid, "R6 grant one cycle after ack", gnt_valid, 0);
    @(negedge clk);
    chk(gnt_valid && gnt_state == 2'b11 && gnt_core == 2'd2 && gnt_line == 3'd1,
        "R7 directed grant", {gnt_valid, gnt_state, gnt_core, gnt_line}, {1'b1, 2'b11, 2'd2, 3'd1});
    predict(mst[1], mpr[1], 2, 1, nst, npr, mask);
    mst[1] = nst; mpr[1] = npr;
    ack_en = 1'b1;

    // random traffic
    for (int k = 0; k < 400; k++) begin
      int c, l; bit w;
      c = int'($urandom % NC);
      l = int'($urandom % NL);
      w = ($urandom % 3) == 0;
      do_req(c, l, w, w ? "R5 random write" : "R3 random read");
    end

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule